// File: doc/BRIEF.md
# EPROM Word Programming Sequencer

This block is a synchronous controller that writes a block of words into a one-time-programmable memory and then proves the contents. On a start request it turns on the raised core supply, then the raised programming supply. It then makes two passes over the address range. The first pass gives every address exactly one programming strobe and reads nothing back. The second pass reads each word back and compares it with the expected value. A word that does not match gets further strobes, with a read-back after each one, up to a parameterised retry cap. If all words verify, both supplies drop to nominal and every word is read once more and compared.

For each address the expected word is fetched through a request/acknowledge pair. The memory's address, data-out, data-drive enable, active-low strobe and active-low read enable all come straight from the controller. Every time interval is a nanosecond parameter, converted to clock cycles at elaboration from the clock-frequency parameter. One shared down-counter times every interval. When the run ends the block reports done, pass, the first failing address and the phase in which that failure was found.

Top module: `eprom_burn_seq`

## Requirements
- R1: Out of reset, and until start is pulsed: done and pass are low, the strobe and read enable are high, both supply requests are low, data drive is off and no expected word is requested.
- R2: The core supply request rises at least SETUP cycles before the programming supply request. The programming supply request falls at least SETUP cycles before the core supply request. The programming supply request is never high while the core supply request is low.
- R3: The first 2^ADDR_W strobes go to addresses 0, 1, 2 … in ascending order. No read-back cycle comes before the last of them.
- R4: Each strobe is low for exactly PULSE cycles. While it is low, the data bus is driven with the expected word for the strobed address, and both raised supplies are requested.
- R5: Data is driven and stable for at least SETUP cycles before a strobe falls, and stays driven for at least HOLD cycles after it rises.
- R6: Read enable is low for OE cycles, and the word is sampled at the end of the last of them. Data drive is never on while read enable is low. After read enable rises, data drive stays off for at least FLOAT cycles.
- R7: In the verify pass, a word that needs k ≤ MAX_PULSES+1 strobes in total to read correctly receives exactly k strobes.
- R8: A word still unverified after MAX_PULSES retry strobes (MAX_PULSES+1 in total) ends the run. The block reports fail phase 1 with that address, gives no further strobes, lowers both supplies and reads nothing at nominal supply.
- R9: After a clean verify pass, every word is read once with both supply requests low. The first mismatching address is reported with fail phase 2.
- R10: The expected-word request stays high with a stable address until acknowledged, and the word is taken in the acknowledge cycle.
- R11: Done rises at the end of a run. Pass is high only if no failure occurred. The fail-phase encoding is 0 none, 1 verify, 2 final compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a run (accepted while idle or done) |
| exp_req_o | output | 1 | Expected-word request for mem_addr_o |
| exp_ack_i | input | 1 | Expected word valid |
| exp_data_i | input | DATA_W | Expected word |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_data_o | output | DATA_W | Word to program |
| mem_data_oe_o | output | 1 | Drive mem_data_o onto the memory bus |
| mem_data_i | input | DATA_W | Word read back from the memory |
| prog_n_o | output | 1 | Active-low programming strobe |
| rd_n_o | output | 1 | Active-low read enable |
| vcc_hi_o | output | 1 | Request raised core supply |
| vpp_hi_o | output | 1 | Request raised programming supply |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished without failure |
| fail_addr_o | output | ADDR_W | First failing address |
| fail_phase_o | output | 2 | 0 none, 1 verify, 2 final compare |

## Verification
A retry word has two outcomes that land on the same read-back. After the last permitted retry strobe, a matching read-back and a reached retry cap both hold in the same cycle. The match must win and the sweep must go on. The bench provokes this with a modelled cell that needs exactly MAX_PULSES+1 strobes, so the run must pass. It then uses a cell that needs one strobe more, so the run must stop at that address with fail phase 1. Strobe counts per address, supply states and read-backs at nominal are compared with counts worked out from the configured cell needs.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_VCC_UP, ST_VPP_UP, ST_FETCH, ST_DRIVE, ST_STROBE,
      ST_HOLD, ST_READ, ST_FLOAT, ST_VPP_DN, ST_VCC_DN, ST_DONE
   } burn_state_t;

   typedef enum logic [1:0] {
      PH_BLIND  = 2'd0,
      PH_VERIFY = 2'd1,
      PH_FINAL  = 2'd2
   } burn_phase_t;

   localparam logic [1:0] FAIL_NONE   = 2'd0;
   localparam logic [1:0] FAIL_VERIFY = 2'd1;
   localparam logic [1:0] FAIL_FINAL  = 2'd2;

   // Round a nanosecond interval up to whole clock cycles, never below one.
   function automatic int unsigned ns_to_cycles(longint unsigned ns, longint unsigned clk_hz);
      longint unsigned c;
      c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return c[31:0];
   endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          zero_o
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= load_val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/burn_addr_ctr.sv
module burn_addr_ctr #(
   parameter int unsigned ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      addr_o <= '0;
      else if (clr_i)  addr_o <= '0;
      else if (inc_i)  addr_o <= addr_o + 1'b1;
   end

   assign last_o = &addr_o;
endmodule

// File: rtl/burn_word_cmp.sv
module burn_word_cmp #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANE_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              match_o
);
   localparam int unsigned LANES = (DATA_W + LANE_W - 1) / LANE_W;
   logic [LANES-1:0] lane_eq;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned LO = g * LANE_W;
      localparam int unsigned HI = (LO + LANE_W > DATA_W) ? DATA_W - 1 : LO + LANE_W - 1;
      assign lane_eq[g] = (a_i[HI:LO] == b_i[HI:LO]);
   end

   assign match_o = &lane_eq;
endmodule

// File: rtl/burn_fsm.sv
module burn_fsm
   import eprom_burn_pkg::*;
#(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned MAX_PULSES = 10,
   parameter int unsigned TW         = 8,
   parameter int unsigned PW_CYC     = 2,
   parameter int unsigned SU_CYC     = 2,
   parameter int unsigned HD_CYC     = 2,
   parameter int unsigned OE_CYC     = 2,
   parameter int unsigned FL_CYC     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              exp_ack_i,
   input  logic [DATA_W-1:0] exp_data_i,
   input  logic              match_i,
   input  logic              tmr_zero_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              addr_last_i,
   output logic              tmr_load_o,
   output logic [TW-1:0]     tmr_val_o,
   output logic              addr_clr_o,
   output logic              addr_inc_o,
   output logic              exp_req_o,
   output logic [DATA_W-1:0] exp_word_o,
   output logic              data_oe_o,
   output logic              prog_n_o,
   output logic              rd_n_o,
   output logic              vcc_hi_o,
   output logic              vpp_hi_o,
   output logic              done_o,
   output logic              pass_o,
   output logic [ADDR_W-1:0] fail_addr_o,
   output logic [1:0]        fail_phase_o
);
   localparam int unsigned RW = $clog2(MAX_PULSES + 1);
   localparam logic [TW-1:0] L_PW = TW'(PW_CYC - 1);
   localparam logic [TW-1:0] L_SU = TW'(SU_CYC - 1);
   localparam logic [TW-1:0] L_HD = TW'(HD_CYC - 1);
   localparam logic [TW-1:0] L_OE = TW'(OE_CYC - 1);
   localparam logic [TW-1:0] L_FL = TW'(FL_CYC - 1);
   localparam logic [RW-1:0] RETRY_CAP = RW'(MAX_PULSES);

   burn_state_t state_q, state_d;
   burn_phase_t phase_q;
   logic [RW-1:0]     retry_q;
   logic [DATA_W-1:0] exp_q;
   logic              match_q;
   logic              failed_q;
   logic [ADDR_W-1:0] fail_addr_q;
   logic [1:0]        fail_phase_q;
   logic              launch;
   logic              work_st;

   assign launch = (state_q == ST_IDLE || state_q == ST_DONE) && start_i;

   always_comb begin
      state_d    = state_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      addr_clr_o = 1'b0;
      addr_inc_o = 1'b0;
      unique case (state_q)
         ST_IDLE, ST_DONE:
            if (start_i) begin
               state_d = ST_VCC_UP; tmr_load_o = 1'b1; tmr_val_o = L_SU;
            end
         ST_VCC_UP:
            if (tmr_zero_i) begin
               state_d = ST_VPP_UP; tmr_load_o = 1'b1; tmr_val_o = L_SU;
            end
         ST_VPP_UP:
            if (tmr_zero_i) begin
               state_d = ST_FETCH; addr_clr_o = 1'b1;
            end
         ST_FETCH:
            if (exp_ack_i) begin
               tmr_load_o = 1'b1;
               if (phase_q == PH_BLIND) begin
                  state_d = ST_DRIVE; tmr_val_o = L_SU;
               end else begin
                  state_d = ST_READ;  tmr_val_o = L_OE;
               end
            end
         ST_DRIVE:
            if (tmr_zero_i) begin
               state_d = ST_STROBE; tmr_load_o = 1'b1; tmr_val_o = L_PW;
            end
         ST_STROBE:
            if (tmr_zero_i) begin
               state_d = ST_HOLD; tmr_load_o = 1'b1; tmr_val_o = L_HD;
            end
         ST_HOLD:
            if (tmr_zero_i) begin
               if (phase_q == PH_BLIND) begin
                  state_d = ST_FETCH;
                  if (addr_last_i) addr_clr_o = 1'b1;
                  else             addr_inc_o = 1'b1;
               end else begin
                  state_d = ST_READ; tmr_load_o = 1'b1; tmr_val_o = L_OE;
               end
            end
         ST_READ:
            if (tmr_zero_i) begin
               state_d = ST_FLOAT; tmr_load_o = 1'b1; tmr_val_o = L_FL;
            end
         ST_FLOAT:
            if (tmr_zero_i) begin
               if (phase_q == PH_VERIFY) begin
                  if (match_q) begin
                     if (addr_last_i) begin
                        state_d = ST_VPP_DN; tmr_load_o = 1'b1; tmr_val_o = L_SU;
                     end else begin
                        state_d = ST_FETCH; addr_inc_o = 1'b1;
                     end
                  end else if (retry_q == RETRY_CAP) begin
                     state_d = ST_VPP_DN; tmr_load_o = 1'b1; tmr_val_o = L_SU;
                  end else begin
                     state_d = ST_DRIVE; tmr_load_o = 1'b1; tmr_val_o = L_SU;
                  end
               end else begin
                  if (addr_last_i) state_d = ST_DONE;
                  else begin
                     state_d = ST_FETCH; addr_inc_o = 1'b1;
                  end
               end
            end
         ST_VPP_DN:
            if (tmr_zero_i) begin
               state_d = ST_VCC_DN; tmr_load_o = 1'b1; tmr_val_o = L_SU;
            end
         ST_VCC_DN:
            if (tmr_zero_i) begin
               if (failed_q) state_d = ST_DONE;
               else begin
                  state_d = ST_FETCH; addr_clr_o = 1'b1;
               end
            end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         phase_q      <= PH_BLIND;
         retry_q      <= '0;
         exp_q        <= '0;
         match_q      <= 1'b0;
         failed_q     <= 1'b0;
         fail_addr_q  <= '0;
         fail_phase_q <= FAIL_NONE;
      end else begin
         state_q <= state_d;
         if (launch) begin
            phase_q      <= PH_BLIND;
            retry_q      <= '0;
            failed_q     <= 1'b0;
            fail_addr_q  <= '0;
            fail_phase_q <= FAIL_NONE;
         end
         if (state_q == ST_FETCH && exp_ack_i) begin
            exp_q   <= exp_data_i;
            retry_q <= '0;
         end
         if (state_q == ST_HOLD && tmr_zero_i && phase_q == PH_BLIND && addr_last_i)
            phase_q <= PH_VERIFY;
         if (state_q == ST_READ && tmr_zero_i)
            match_q <= match_i;
         if (state_q == ST_FLOAT && tmr_zero_i && !match_q) begin
            if (phase_q == PH_VERIFY) begin
               if (retry_q == RETRY_CAP) begin
                  failed_q     <= 1'b1;
                  fail_addr_q  <= addr_i;
                  fail_phase_q <= FAIL_VERIFY;
               end else begin
                  retry_q <= retry_q + 1'b1;
               end
            end else if (!failed_q) begin
               failed_q     <= 1'b1;
               fail_addr_q  <= addr_i;
               fail_phase_q <= FAIL_FINAL;
            end
         end
         if (state_q == ST_VCC_DN && tmr_zero_i && !failed_q)
            phase_q <= PH_FINAL;
      end
   end

   assign work_st = (state_q == ST_FETCH) || (state_q == ST_DRIVE) || (state_q == ST_STROBE) ||
                    (state_q == ST_HOLD)  || (state_q == ST_READ)  || (state_q == ST_FLOAT);

   assign vcc_hi_o     = (state_q == ST_VCC_UP) || (state_q == ST_VPP_UP) ||
                         (state_q == ST_VPP_DN) || (work_st && phase_q != PH_FINAL);
   assign vpp_hi_o     = (state_q == ST_VPP_UP) || (work_st && phase_q != PH_FINAL);
   assign exp_req_o    = (state_q == ST_FETCH);
   assign exp_word_o   = exp_q;
   assign data_oe_o    = (state_q == ST_DRIVE) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
   assign prog_n_o     = (state_q != ST_STROBE);
   assign rd_n_o       = (state_q != ST_READ);
   assign done_o       = (state_q == ST_DONE);
   assign pass_o       = done_o && !failed_q;
   assign fail_addr_o  = fail_addr_q;
   assign fail_phase_o = fail_phase_q;

   p_vpp_under_vcc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_hi_o |-> vcc_hi_o);
   p_vcc_leads_vpp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vpp_hi_o) |-> $past(vcc_hi_o));
   p_strobe_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> (data_oe_o && vpp_hi_o && vcc_hi_o));
   p_bus_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !data_oe_o);
   p_retry_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      retry_q <= RETRY_CAP);
   p_final_nominal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FINAL && !rd_n_o) |-> (!vcc_hi_o && !vpp_hi_o));
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_req_o && !exp_ack_i) |=> (exp_req_o && $stable(addr_i)));
endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
   import eprom_burn_pkg::*;
#(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned MAX_PULSES = 10,
   parameter int unsigned CLK_HZ     = 100_000_000,
   parameter int unsigned PULSE_NS   = 50_000,
   parameter int unsigned SETUP_NS   = 2_000,
   parameter int unsigned HOLD_NS    = 2_000,
   parameter int unsigned OE_NS      = 150,
   parameter int unsigned FLOAT_NS   = 130
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              exp_req_o,
   input  logic              exp_ack_i,
   input  logic [DATA_W-1:0] exp_data_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic              mem_data_oe_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              prog_n_o,
   output logic              rd_n_o,
   output logic              vcc_hi_o,
   output logic              vpp_hi_o,
   output logic              done_o,
   output logic              pass_o,
   output logic [ADDR_W-1:0] fail_addr_o,
   output logic [1:0]        fail_phase_o
);
   localparam int unsigned PW_CYC = ns_to_cycles(PULSE_NS, CLK_HZ);
   localparam int unsigned SU_CYC = ns_to_cycles(SETUP_NS, CLK_HZ);
   localparam int unsigned HD_CYC = ns_to_cycles(HOLD_NS,  CLK_HZ);
   localparam int unsigned OE_CYC = ns_to_cycles(OE_NS,    CLK_HZ);
   localparam int unsigned FL_CYC = ns_to_cycles(FLOAT_NS, CLK_HZ);
   localparam int unsigned M1 = (PW_CYC > SU_CYC) ? PW_CYC : SU_CYC;
   localparam int unsigned M2 = (HD_CYC > OE_CYC) ? HD_CYC : OE_CYC;
   localparam int unsigned M3 = (M1 > M2) ? M1 : M2;
   localparam int unsigned MAX_CYC = (M3 > FL_CYC) ? M3 : FL_CYC;
   localparam int unsigned TW = $clog2(MAX_CYC + 1);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 1..32");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (MAX_PULSES < 1) begin : g_bad_retry
      $error("MAX_PULSES must be at least 1");
   end
   if (64'(PW_CYC) * 64'd100_000_000_000 > 64'(PULSE_NS) * 64'd105 * 64'(CLK_HZ)) begin : g_bad_pw
      $error("Clock too coarse: rounded strobe exceeds +5 percent of PULSE_NS");
   end

   logic              tmr_load, tmr_zero;
   logic [TW-1:0]     tmr_val;
   logic              addr_clr, addr_inc, addr_last;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] exp_word;
   logic              match;

   burn_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
   );

   burn_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr_i(addr_clr), .inc_i(addr_inc),
      .addr_o(addr), .last_o(addr_last)
   );

   burn_word_cmp #(.DATA_W(DATA_W), .LANE_W(8)) u_cmp (
      .a_i(mem_data_i), .b_i(exp_word), .match_o(match)
   );

   burn_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PULSES(MAX_PULSES), .TW(TW),
      .PW_CYC(PW_CYC), .SU_CYC(SU_CYC), .HD_CYC(HD_CYC), .OE_CYC(OE_CYC), .FL_CYC(FL_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .exp_ack_i(exp_ack_i), .exp_data_i(exp_data_i), .match_i(match),
      .tmr_zero_i(tmr_zero), .addr_i(addr), .addr_last_i(addr_last),
      .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
      .addr_clr_o(addr_clr), .addr_inc_o(addr_inc),
      .exp_req_o(exp_req_o), .exp_word_o(exp_word),
      .data_oe_o(mem_data_oe_o), .prog_n_o(prog_n_o), .rd_n_o(rd_n_o),
      .vcc_hi_o(vcc_hi_o), .vpp_hi_o(vpp_hi_o),
      .done_o(done_o), .pass_o(pass_o),
      .fail_addr_o(fail_addr_o), .fail_phase_o(fail_phase_o)
   );

   assign mem_addr_o = addr;
   assign mem_data_o = exp_word;
endmodule

// File: tb/tb_eprom_burn_seq.sv
module tb_eprom_burn_seq;
   localparam int AW = 3;
   localparam int N  = 8;
   localparam int PW = 6, SU = 3, HD = 2, OE = 3, FL = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic exp_req, exp_ack = 1'b0;
   logic [15:0] exp_data = '0;
   logic [AW-1:0] mem_addr, fail_addr;
   logic [15:0] mem_dout, mem_din;
   logic data_oe, prog_n, rd_n, vcc_hi, vpp_hi, done, pass;
   logic [1:0] fail_phase;

   eprom_burn_seq #(.ADDR_W(AW), .DATA_W(16), .MAX_PULSES(10), .CLK_HZ(125_000_000),
      .PULSE_NS(48), .SETUP_NS(24), .HOLD_NS(16), .OE_NS(24), .FLOAT_NS(16)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .exp_req_o(exp_req), .exp_ack_i(exp_ack),
      .exp_data_i(exp_data), .mem_addr_o(mem_addr), .mem_data_o(mem_dout),
      .mem_data_oe_o(data_oe), .mem_data_i(mem_din), .prog_n_o(prog_n), .rd_n_o(rd_n),
      .vcc_hi_o(vcc_hi), .vpp_hi_o(vpp_hi), .done_o(done), .pass_o(pass),
      .fail_addr_o(fail_addr), .fail_phase_o(fail_phase));

   always #4 clk = ~clk;

   int checks = 0, failures = 0, cyc = 0;
   logic [15:0] exp_mem [N];
   int need [N];
   int pulses [N];
   bit corrupt [N];
   int ack_delay = 0, wcnt = 0, rd_low = 0;
   int v_r2, v_r3, v_r4, v_r5, v_r6, v_r10, nom_reads;

   for (genvar g = 0; g < N; g++) begin : g_exp
      assign exp_mem[g] = 16'(g * 16'h1357) ^ 16'h0A5C;
   end

   // Memory cell model: needs need[a] strobes; data only valid OE-1 edges into a read.
   always_comb begin
      if (rd_n) mem_din = 16'h0000;
      else if (rd_low < OE - 1) mem_din = exp_mem[mem_addr] ^ 16'h5A5A;
      else if (!vcc_hi && corrupt[mem_addr]) mem_din = exp_mem[mem_addr] ^ 16'h8000;
      else if (pulses[mem_addr] >= need[mem_addr]) mem_din = exp_mem[mem_addr];
      else mem_din = exp_mem[mem_addr] ^ 16'h0001;
   end

   always @(posedge clk) rd_low <= rd_n ? 0 : rd_low + 1;

   // Expected-word source
   always @(negedge clk) begin
      if (!rst_n) begin exp_ack <= 1'b0; wcnt = 0; end
      else if (exp_ack) exp_ack <= 1'b0;
      else if (exp_req) begin
         if (wcnt >= ack_delay) begin
            exp_ack <= 1'b1; exp_data <= exp_mem[mem_addr]; wcnt = 0;
         end else wcnt++;
      end
   end

   // Protocol monitor
   logic p_prog, p_rd, p_vcc, p_vpp, p_req, hold_act, fl_act;
   logic [15:0] p_dout, pulse_data;
   logic [AW-1:0] p_addr;
   int vcc_run, vpp_low, oe_run, low_run, hold_run, fl_run, pidx, reads;
   always @(negedge clk) begin
      if (!rst_n) begin
         p_prog = 1; p_rd = 1; p_vcc = 0; p_vpp = 0; p_req = 0; hold_act = 0; fl_act = 0;
         p_dout = '0; pulse_data = '0; p_addr = '0;
         vcc_run = 0; vpp_low = 0; oe_run = 0; low_run = 0; hold_run = 0; fl_run = 0;
         pidx = 0; reads = 0;
      end else begin
         // R2 supplies
         if (vpp_hi && !vcc_hi) v_r2++;
         if (vpp_hi && !p_vpp && vcc_run < SU) v_r2++;
         if (!vcc_hi && p_vcc && vpp_low < SU) v_r2++;
         vcc_run = vcc_hi ? vcc_run + 1 : 0;
         vpp_low = vpp_hi ? 0 : vpp_low + 1;
         // strobes R3 R4 R5
         if (!prog_n && p_prog) begin
            pulses[mem_addr]++;
            if (mem_dout !== exp_mem[mem_addr] || !data_oe) v_r4++;
            if (oe_run < SU) v_r5++;
            if (pidx < N && (mem_addr != AW'(pidx) || reads != 0)) v_r3++;
            pidx++; low_run = 1; pulse_data = mem_dout;
         end else if (!prog_n) begin
            low_run++;
            if (mem_dout !== pulse_data || !vpp_hi) v_r4++;
         end else if (!p_prog) begin
            if (low_run != PW) v_r4++;
            hold_act = 1; hold_run = 1;
         end else if (hold_act) begin
            if (data_oe) hold_run++;
            else begin if (hold_run < HD) v_r5++; hold_act = 0; end
         end
         oe_run = (data_oe && mem_dout == p_dout) ? oe_run + 1 : (data_oe ? 1 : 0);
         // reads R6 R9
         if (!rd_n && data_oe) v_r6++;
         if (!rd_n && p_rd) begin reads++; if (!vcc_hi && !vpp_hi) nom_reads++; end
         if (rd_n && !p_rd) begin fl_act = 1; fl_run = 1; end
         else if (fl_act) begin
            if (data_oe) begin if (fl_run < FL) v_r6++; fl_act = 0; end
            else fl_run++;
         end
         // R10 request hold
         if (exp_req && p_req && mem_addr != p_addr) v_r10++;
         p_prog = prog_n; p_rd = rd_n; p_vcc = vcc_hi; p_vpp = vpp_hi;
         p_req = exp_req && !exp_ack; p_dout = mem_dout; p_addr = mem_addr;
      end
   end

   task automatic check(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic reset_all();
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) pulses[i] = 0;
      v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; v_r10 = 0; nom_reads = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   task automatic run_once();
      int n = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done && n < 20000) begin @(negedge clk); n++; end
      check("R11 done reached", int'(done), 1);
   endtask

   task automatic check_monitors();
      check("R2 supply order", v_r2, 0);
      check("R3 blind order", v_r3, 0);
      check("R4 strobe width/data", v_r4, 0);
      check("R5 setup/hold", v_r5, 0);
      check("R6 read turnaround", v_r6, 0);
      check("R10 request hold", v_r10, 0);
      check("R8 supplies off at end", int'(vcc_hi | vpp_hi), 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin need[i] = 1; corrupt[i] = 0; end
      reset_all();
      repeat (2) @(negedge clk);
      // R1 reset/idle state
      check("R1 done", int'(done), 0);
      check("R1 pass", int'(pass), 0);
      check("R1 prog_n", int'(prog_n), 1);
      check("R1 rd_n", int'(rd_n), 1);
      check("R1 supplies", int'({vcc_hi, vpp_hi}), 0);
      check("R1 drive/req", int'({data_oe, exp_req}), 0);

      // Scenario A: every cell programs in one strobe
      ack_delay = 0;
      run_once();
      check("R11 pass A", int'(pass), 1);
      check("R11 phase A", int'(fail_phase), 0);
      for (int i = 0; i < N; i++) check("R3 one strobe A", pulses[i], 1);
      check("R9 nominal reads A", nom_reads, N);
      check_monitors();

      // Scenario B: sweep of cell needs, incl. cap boundary (MAX+1 = 11 passes)
      reset_all();
      for (int i = 0; i < N; i++) need[i] = i + 1;
      need[6] = 11; need[7] = 2; ack_delay = 2;
      run_once();
      check("R7 pass B", int'(pass), 1);
      for (int i = 0; i < N; i++) check("R7 strobes per word", pulses[i], need[i]);
      check("R9 nominal reads B", nom_reads, N);
      check_monitors();

      // Scenario C: cell at address 4 needs 12 -> cap reached
      reset_all();
      for (int i = 0; i < N; i++) need[i] = 1;
      need[4] = 12; ack_delay = 1;
      run_once();
      check("R8 pass C", int'(pass), 0);
      check("R8 phase C", int'(fail_phase), 1);
      check("R8 addr C", int'(fail_addr), 4);
      for (int i = 0; i < N; i++) check("R8 strobes C", pulses[i], (i == 4) ? 11 : 1);
      check("R8 no nominal reads", nom_reads, 0);
      check_monitors();

      // Scenario D: nominal-supply mismatches at 2 and 6
      reset_all();
      need[4] = 1; need[0] = 3; corrupt[2] = 1; corrupt[6] = 1; ack_delay = 3;
      run_once();
      check("R9 pass D", int'(pass), 0);
      check("R9 phase D", int'(fail_phase), 2);
      check("R9 first addr D", int'(fail_addr), 2);
      check("R9 all words read D", nom_reads, N);
      check("R7 strobes addr0 D", pulses[0], 3);
      check_monitors();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule